// File: doc/BRIEF.md
# Composite peripheral clock generator

This block derives one peripheral clock from four reference sources. Everything runs in a single system clock domain. Each reference is represented by an enable input that marks the system-clock cycles on which that reference ticks. A source selector picks one of the four enables. A divider then counts the selected ticks over a period that is either the product of two 3-bit factors or a fixed ratio of 2 or 4. A gate with disable polarity can silence the result.

The block produces two outputs. One is a single-cycle clock-enable pulse, issued once per division period. The other is a clock-level signal with a duty cycle of about one half, suitable for driving a gated clock cell downstream. A reserved factor code leaves the output idle and raises an error flag.

Configuration goes through a small word-addressed register port. New source or divider settings are adopted only when the running period ends, so the output never shows a shortened period.

Top module: `periph_clk_gen`

## Requirements
- R1: After reset the register port reads: source 0, both factors 1, single ratio 0, path select 0 and disable 0. `cfg_err_o` is 0, and no enable pulse is produced while reset is held.
- R2: A read returns the addressed register on `reg_rdata` one clock after the address is presented. Unused bits read 0, and any unmapped address reads 0. The register map (byte addresses) is:
  - 0x00: source in bits [1:0]
  - 0x04: factor A in bits [2:0]
  - 0x08: factor B in bits [2:0]
  - 0x0C: single ratio in bit 0
  - 0x10: path select in bit 0
  - 0x14: disable in bit 0
- R3: Only cycles on which `src_en[s]` is high advance the divider, where s is the selected source.
- R4: With path select 0, one pulse is issued on `clk_en_o` every A×B selected ticks, where A and B are factor codes 1 to 6 taken as their own values.
- R5: A factor code of 0 or 7 with path select 0 stops all pulses and holds `clk_lvl_o` low. `cfg_err_o` reads 1 from the clock after the write, and returns to 0 once both codes are valid.
- R6: With path select 1, the period is 2 ticks when the single ratio is 0 and 4 ticks when it is 1. The factor codes are then ignored and do not raise `cfg_err_o`.
- R7: While the disable bit is 1, `clk_en_o` and `clk_lvl_o` stay low. Clearing the bit restores them.
- R8: A new source or divisor is adopted only at the terminal tick of the running period. A write on the same edge as a terminal tick takes effect one period later.
- R9: For a divisor D, `clk_lvl_o` is high during the first ceil(D/2) ticks of each period and low during the rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_en | input | 4 | Tick qualifiers of the four reference sources |
| reg_addr | input | 5 | Register byte address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one clock after the address |
| clk_en_o | output | 1 | One-cycle pulse per division period |
| clk_lvl_o | output | 1 | Gated divided clock level |
| cfg_err_o | output | 1 | A reserved factor code is programmed |

## Verification
The delicate coincidence is a register write landing on the same edge as a terminal tick: the reload at that edge must take the old divisor and adopt the new one only at the following terminal tick. The bench provokes this with divisor 1 on an always-ticking source, so every edge is terminal, and then writes factor A = 2. It judges the outcome from the pulse train on the following four cycles, which must read 1, 1, 0, 1. A second case writes while a 36-tick period is running and requires the next pulse to arrive exactly 36 cycles after the previous one.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

    // byte offsets of the configuration words
    localparam int unsigned OFS_SRC  = 32'h00;
    localparam int unsigned OFS_FACA = 32'h04;
    localparam int unsigned OFS_FACB = 32'h08;
    localparam int unsigned OFS_HALF = 32'h0C;
    localparam int unsigned OFS_PATH = 32'h10;
    localparam int unsigned OFS_GATE = 32'h14;

    // ratio carried by one factor code: codes above top and code 0 are reserved
    function automatic int unsigned field_ratio(input int unsigned code, input int unsigned top);
        return (code == 0 || code > top) ? 0 : code;
    endfunction

endpackage

// File: rtl/pclk_regfile.sv
module pclk_regfile #(
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned SEL_W     = 2,
    parameter int unsigned FIELD_W   = 3,
    parameter int unsigned FIELD_MAX = 6,
    parameter int unsigned DIV_W     = 2 * FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [SEL_W-1:0]  shadow_src,
    output logic [DIV_W-1:0]  shadow_div,
    output logic              gate_off,
    output logic              cfg_err
);
    import pclk_pkg::*;

    typedef struct packed {
        logic [SEL_W-1:0]   src;
        logic [FIELD_W-1:0] fac_a;
        logic [FIELD_W-1:0] fac_b;
        logic               half;
        logic               path;
        logic               dis;
        logic               err;
        logic [DATA_W-1:0]  rdata;
    } rf_t;

    rf_t s_q, s_d;
    logic [DIV_W-1:0] ratio_a, ratio_b;
    logic unused_wdata;

    assign unused_wdata = ^reg_wdata;

    always_comb begin
        s_d = s_q;
        // read mux returns the stored value before any write of this cycle
        s_d.rdata = '0;
        case (reg_addr)
            ADDR_W'(OFS_SRC):  s_d.rdata[SEL_W-1:0]   = s_q.src;
            ADDR_W'(OFS_FACA): s_d.rdata[FIELD_W-1:0] = s_q.fac_a;
            ADDR_W'(OFS_FACB): s_d.rdata[FIELD_W-1:0] = s_q.fac_b;
            ADDR_W'(OFS_HALF): s_d.rdata[0]           = s_q.half;
            ADDR_W'(OFS_PATH): s_d.rdata[0]           = s_q.path;
            ADDR_W'(OFS_GATE): s_d.rdata[0]           = s_q.dis;
            default:           s_d.rdata              = '0;
        endcase
        if (reg_we) begin
            case (reg_addr)
                ADDR_W'(OFS_SRC):  s_d.src   = reg_wdata[SEL_W-1:0];
                ADDR_W'(OFS_FACA): s_d.fac_a = reg_wdata[FIELD_W-1:0];
                ADDR_W'(OFS_FACB): s_d.fac_b = reg_wdata[FIELD_W-1:0];
                ADDR_W'(OFS_HALF): s_d.half  = reg_wdata[0];
                ADDR_W'(OFS_PATH): s_d.path  = reg_wdata[0];
                ADDR_W'(OFS_GATE): s_d.dis   = reg_wdata[0];
                default: ;
            endcase
        end
        // error flag follows the post-write settings
        s_d.err = !s_d.path &&
                  (field_ratio(32'(s_d.fac_a), FIELD_MAX) == 0 ||
                   field_ratio(32'(s_d.fac_b), FIELD_MAX) == 0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.fac_a <= FIELD_W'(1);
            s_q.fac_b <= FIELD_W'(1);
        end else begin
            s_q <= s_d;
        end
    end

    // divisor offered to the divider for its next reload
    always_comb begin
        ratio_a = DIV_W'(field_ratio(32'(s_q.fac_a), FIELD_MAX));
        ratio_b = DIV_W'(field_ratio(32'(s_q.fac_b), FIELD_MAX));
        if (s_q.path) begin
            shadow_div = s_q.half ? DIV_W'(4) : DIV_W'(2);
        end else begin
            shadow_div = DIV_W'(ratio_a * ratio_b);
        end
    end

    assign shadow_src = s_q.src;
    assign gate_off   = s_q.dis;
    assign cfg_err    = s_q.err;
    assign reg_rdata  = s_q.rdata;

endmodule

// File: rtl/pclk_divider.sv
module pclk_divider #(
    parameter int unsigned NUM_SRC = 4,
    parameter int unsigned SEL_W   = 2,
    parameter int unsigned DIV_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [SEL_W-1:0]   shadow_src,
    input  logic [DIV_W-1:0]   shadow_div,
    output logic               term,
    output logic               lvl_raw,
    output logic [DIV_W-1:0]   act_div
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] div;
        logic [SEL_W-1:0] src;
    } dv_t;

    dv_t d_q, d_d;
    logic [NUM_SRC-1:0] hit;
    logic               tick;
    logic               valid;
    logic [DIV_W:0]     high_len;

    // one-hot qualified selection of the active reference
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_sel
        assign hit[g] = src_en[g] && (d_q.src == SEL_W'(g));
    end
    assign tick = |hit;

    always_comb begin
        d_d      = d_q;
        valid    = (d_q.div != '0);
        term     = valid && tick && (d_q.cnt == d_q.div - 1'b1);
        high_len = ({1'b0, d_q.div} + (DIV_W+1)'(1)) >> 1;
        lvl_raw  = valid && ({1'b0, d_q.cnt} < high_len);
        if (!valid || term) begin
            // idle or period end: adopt the programmed settings
            d_d.cnt = '0;
            d_d.div = shadow_div;
            d_d.src = shadow_src;
        end else if (tick) begin
            d_d.cnt = d_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q     <= '0;
            d_q.div <= DIV_W'(1);
        end else begin
            d_q <= d_d;
        end
    end

    assign act_div = d_q.div;

endmodule

// File: rtl/pclk_outgate.sv
module pclk_outgate (
    input  logic clk,
    input  logic rst_n,
    input  logic term,
    input  logic lvl_raw,
    input  logic gate_off,
    output logic en_o,
    output logic lvl_o
);
    typedef struct packed {
        logic en;
        logic lvl;
    } og_t;

    og_t g_q, g_d;

    always_comb begin
        g_d.en  = term && !gate_off;
        g_d.lvl = lvl_raw && !gate_off;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign en_o  = g_q.en;
    assign lvl_o = g_q.lvl;

endmodule

// File: rtl/periph_clk_gen.sv
module periph_clk_gen #(
    parameter int unsigned NUM_SRC   = 4,
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned FIELD_W   = 3,
    parameter int unsigned FIELD_MAX = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_we,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               clk_en_o,
    output logic               clk_lvl_o,
    output logic               cfg_err_o
);
    localparam int unsigned SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int unsigned DIV_W = 2 * FIELD_W;

    logic [SEL_W-1:0] shadow_src;
    logic [DIV_W-1:0] shadow_div;
    logic [DIV_W-1:0] act_div;
    logic             gate_off;
    logic             div_term;
    logic             lvl_raw;

    pclk_regfile #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W),
        .FIELD_W(FIELD_W), .FIELD_MAX(FIELD_MAX), .DIV_W(DIV_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .shadow_src(shadow_src), .shadow_div(shadow_div),
        .gate_off(gate_off), .cfg_err(cfg_err_o)
    );

    pclk_divider #(
        .NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .DIV_W(DIV_W)
    ) u_div (
        .clk(clk), .rst_n(rst_n), .src_en(src_en),
        .shadow_src(shadow_src), .shadow_div(shadow_div),
        .term(div_term), .lvl_raw(lvl_raw), .act_div(act_div)
    );

    pclk_outgate u_gate (
        .clk(clk), .rst_n(rst_n),
        .term(div_term), .lvl_raw(lvl_raw), .gate_off(gate_off),
        .en_o(clk_en_o), .lvl_o(clk_lvl_o)
    );

endmodule

// File: rtl/periph_clk_gen_chk.sv
module periph_clk_gen_chk #(
    parameter int unsigned NUM_SRC = 4,
    parameter int unsigned ADDR_W  = 5,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned DIV_W   = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_en,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic               reg_we,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic               en_o,
    input logic               lvl_o,
    input logic               gate_off,
    input logic [DIV_W-1:0]   act_div
);
    // R7
    gate_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |-> !$past(gate_off));

    // R7
    gate_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_o |-> !$past(gate_off));

    // R5
    idle_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_div == '0) |=> !en_o);

    // R3
    pulse_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |-> ($past(src_en) != '0));

    // R2
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_we && !$past(reg_we) && $stable(reg_addr)) |=> $stable(reg_rdata));

endmodule

bind periph_clk_gen periph_clk_gen_chk #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .src_en(src_en),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_rdata(reg_rdata),
    .en_o(clk_en_o), .lvl_o(clk_lvl_o),
    .gate_off(gate_off), .act_div(act_div)
);

// File: tb/periph_clk_gen_bench.sv
`timescale 1ns/1ps
module periph_clk_gen_bench;

    localparam int WIN = 144;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_en = '0;
    logic [4:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        clk_en_o, clk_lvl_o, cfg_err_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    periph_clk_gen u_periph_clk_gen (
        .clk(clk), .rst_n(rst_n), .src_en(src_en),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .clk_en_o(clk_en_o), .clk_lvl_o(clk_lvl_o), .cfg_err_o(cfg_err_o)
    );

    // source k ticks every (k+1) cycles
    initial begin
        forever begin
            @(negedge clk);
            cyc = cyc + 1;
            for (int k = 0; k < 4; k++) src_en[k] = ((cyc % (k + 1)) == 0);
        end
    end

    typedef struct packed {
        logic [1:0] src;
        logic [2:0] fa;
        logic [2:0] fb;
        logic       path;
        logic       half;
        logic [7:0] pulses;
        logic [7:0] highs;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 3'd1, 3'd1, 1'b0, 1'b0, 8'd144, 8'd144},
        '{2'd1, 3'd2, 3'd3, 1'b0, 1'b0, 8'd12,  8'd72},
        '{2'd2, 3'd3, 3'd4, 1'b0, 1'b0, 8'd4,   8'd72},
        '{2'd3, 3'd6, 3'd6, 1'b0, 1'b0, 8'd1,   8'd72},
        '{2'd0, 3'd3, 3'd1, 1'b0, 1'b0, 8'd48,  8'd96},
        '{2'd0, 3'd2, 3'd2, 1'b0, 1'b0, 8'd36,  8'd72},
        '{2'd1, 3'd7, 3'd0, 1'b1, 1'b0, 8'd36,  8'd72},
        '{2'd0, 3'd1, 3'd1, 1'b1, 1'b1, 8'd36,  8'd72}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        reg_addr  = 5'(addr);
        reg_wdata = 32'(data);
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input int addr, output int data);
        @(negedge clk);
        reg_addr = 5'(addr);
        @(negedge clk);
        data = int'(reg_rdata);
    endtask

    task automatic window(output int p, output int h);
        p = 0;
        h = 0;
        repeat (WIN) begin
            @(negedge clk);
            p += int'(clk_en_o);
            h += int'(clk_lvl_o);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int v, p, h;
        time t0, t1;
        int gap;
        vec_t cv;

        // R1: outputs quiet while reset is held
        repeat (4) @(negedge clk);
        chk("R1 pulse in reset", int'(clk_en_o), 0);
        rst_n = 1'b1;
        rd(32'h00, v); chk("R1 source", v, 0);
        rd(32'h04, v); chk("R1 factor A", v, 1);
        rd(32'h08, v); chk("R1 factor B", v, 1);
        rd(32'h0C, v); chk("R1 single ratio", v, 0);
        rd(32'h10, v); chk("R1 path", v, 0);
        rd(32'h14, v); chk("R1 disable", v, 0);
        chk("R1 error flag", int'(cfg_err_o), 0);

        // R2: masking and unmapped reads
        wr(32'h00, 32'hFFFF_FFFF);
        rd(32'h00, v); chk("R2 source mask", v, 3);
        rd(32'h18, v); chk("R2 unmapped", v, 0);
        wr(32'h00, 0);

        // table of configurations
        for (int i = 0; i < 8; i++) begin
            cv = VECS[i];
            wr(32'h00, int'(cv.src));
            wr(32'h04, int'(cv.fa));
            wr(32'h08, int'(cv.fb));
            wr(32'h0C, int'(cv.half));
            wr(32'h10, int'(cv.path));
            repeat (300) @(negedge clk);
            window(p, h);
            if (cv.path)           chk("R6 single ratio pulses", p, int'(cv.pulses));
            else if (cv.src != 0)  chk("R3 source pulses", p, int'(cv.pulses));
            else                   chk("R4 product pulses", p, int'(cv.pulses));
            chk("R9 level high cycles", h, int'(cv.highs));
            chk(cv.path ? "R6 no error" : "R5 no error", int'(cfg_err_o), 0);
        end

        // back to source 0, product path, D=1
        wr(32'h10, 0);
        wr(32'h0C, 0);

        // R5: reserved codes
        wr(32'h04, 7);
        chk("R5 error on code 7", int'(cfg_err_o), 1);
        repeat (300) @(negedge clk);
        window(p, h);
        chk("R5 idle pulses code 7", p, 0);
        chk("R5 idle level code 7", h, 0);
        wr(32'h04, 1);
        wr(32'h08, 0);
        chk("R5 error on code 0", int'(cfg_err_o), 1);
        repeat (20) @(negedge clk);
        window(p, h);
        chk("R5 idle pulses code 0", p, 0);
        wr(32'h08, 1);
        chk("R5 error cleared", int'(cfg_err_o), 0);
        repeat (20) @(negedge clk);
        window(p, h);
        chk("R5 recovered pulses", p, 144);

        // R7: gate
        wr(32'h14, 32'hFFFF_FFFF);
        rd(32'h14, v); chk("R2 disable mask", v, 1);
        repeat (4) @(negedge clk);
        window(p, h);
        chk("R7 pulses gated", p, 0);
        chk("R7 level gated", h, 0);
        wr(32'h14, 0);
        repeat (4) @(negedge clk);
        window(p, h);
        chk("R7 pulses restored", p, 144);

        // R8: write during a 36-tick period
        wr(32'h04, 6);
        wr(32'h08, 6);
        repeat (300) @(negedge clk);
        v = 0;
        while (!clk_en_o && v < 200) begin @(negedge clk); v++; end
        t0 = $time;
        wr(32'h04, 1);
        wr(32'h08, 1);
        v = 0;
        @(negedge clk);
        while (!clk_en_o && v < 200) begin @(negedge clk); v++; end
        t1 = $time;
        gap = int'((t1 - t0) / 4);
        chk("R8 old period completes", gap, 36);
        @(negedge clk);
        chk("R8 new period adopted", int'(clk_en_o), 1);

        // R8: write on the same edge as a terminal tick (D=1 running)
        repeat (10) @(negedge clk);
        wr(32'h04, 2);
        chk("R8 coincident edge", int'(clk_en_o), 1);
        @(negedge clk); chk("R8 old divisor one more", int'(clk_en_o), 1);
        @(negedge clk); chk("R8 new divisor gap", int'(clk_en_o), 0);
        @(negedge clk); chk("R8 new divisor pulse", int'(clk_en_o), 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule